// File: doc/BRIEF.md
# Serial Read/Convert ADC Readout Controller

This block sits on the host side of a dual-channel successive-approximation converter whose read and convert pins are tied together. It produces the serial clock, the chip select and a single combined read-plus-convert strobe. Each frame opens with that strobe, which starts a conversion. Two serial clocks then return a channel tag, and sixteen more return the conversion word. An optional idle gap with the serial clock parked low may sit between the tag phase and the data phase.

Each finished frame is presented downstream as one word holding the tag and the data, on a valid/ready pair. While a frame runs, the converter busy line is watched. The converter raises busy on every other strobe, so any break in that alternation means the host has lost step with it, and a sticky error flag is raised.

The serial clock half-period is given in system clock cycles. For a 1 MHz serial clock from a 200 MHz system clock the half-period value is 100.

Top module: `adc_rc_ctrl`

## Requirements
- R1: While rst_ni is low, strobe_o, sclk_o and m_valid_o are low, cs_no is high and sync_err_o is clear.
- R2: strobe_o is high for exactly one serial clock period (2·H system cycles). It rises together with the first serial clock rising edge of the frame. This fixed width cannot be changed by any input.
- R3: A frame has 3 serial clock periods (strobe plus two tag clocks) followed by 16 data periods. That gives 19 rising edges of sclk_o per frame. With no gap, chip select stays low for exactly 2·H·19 system cycles.
- R4: sdo_i is sampled on the falling edge of sclk_o, most significant bit first. The first bit sampled after the strobe period is tag bit 1.
- R5: gap_i = G inserts G serial periods with sclk_o low between the tag and data phases. Chip select then stays low for 2·H·(19+G) cycles, and the captured word is unchanged.
- R6: m_data_o is {tag[1:0], data[15:0]}, with the tag in bits 17:16 exactly as received (for example 2'b10 for the second channel).
- R7: cs_no is low whenever strobe_o or sclk_o is high. It goes low in the same cycle the strobe rises, and it returns high for at least one cycle between frames.
- R8: m_valid_o and m_data_o hold until m_ready_i is seen. With free_run_i low, no new frame starts while a sample is pending.
- R9: With free_run_i high, frames run back to back regardless of m_ready_i, and a pending sample is replaced by the newer one.
- R10: sync_err_o is set, and stays set until reset, when busy is seen in two consecutive strobe intervals, or is absent in two consecutive strobe intervals. A strobe interval runs from one strobe to the next, so the check is made at a strobe.
- R11: div_half_i = H sets the serial clock half-period to H system cycles, and H = 0 acts as H = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Allow new frames to start |
| free_run_i | input | 1 | Start frames without waiting for acceptance |
| div_half_i | input | DIV_W | Serial clock half-period in system cycles |
| gap_i | input | GAP_W | Idle serial periods between tag and data phases |
| sclk_o | output | 1 | Serial clock to converter |
| strobe_o | output | 1 | Combined read/convert strobe |
| cs_no | output | 1 | Active-low chip select |
| sdo_i | input | 1 | Serial data from converter |
| busy_i | input | 1 | Converter busy line (asynchronous) |
| m_valid_o | output | 1 | Sample valid |
| m_ready_i | input | 1 | Sample accepted |
| m_data_o | output | ID_W+DATA_W | {tag, data} |
| sync_err_o | output | 1 | Sticky loss-of-synchronization flag |

## Verification
The strobe rises in the cycle after the start decision and lasts exactly 2·H cycles. Chip select stays low for 2·H·(19+G) cycles, and m_valid_o rises one cycle after chip select is released. The bench counts these spans on falling clock edges and compares them with those formulas. It reads the sample only after it has seen m_valid_o high. The sync flag can only change at the strobe that closes the second interval, so the bench reads it after a fixed number of whole frames.

// File: rtl/adc_rc_pkg.sv
package adc_rc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STRB,
    ST_ID,
    ST_GAP,
    ST_DATA,
    ST_DONE
  } rc_state_e;
endpackage

// File: rtl/adc_rc_timebase.sv
module adc_rc_timebase #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_eff;

  assign half_eff = (half_i == '0) ? ONE : half_i;
  assign tick_o   = !clr_i && (cnt_q == half_eff - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/adc_rc_shift.sv
module adc_rc_shift #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (clr_i) sh_q <= '0;
    else if (en_i)  sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/adc_rc_sync_mon.sv
module adc_rc_sync_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic evt_i,
  output logic err_o
);
  logic b_meta_q, b_sync_q;
  logic seen_q, prev_q, armed_q, have_prev_q, err_q;
  logic cur;

  assign cur = seen_q | b_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_meta_q    <= 1'b0;
      b_sync_q    <= 1'b0;
      seen_q      <= 1'b0;
      prev_q      <= 1'b0;
      armed_q     <= 1'b0;
      have_prev_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      b_meta_q <= busy_i;
      b_sync_q <= b_meta_q;
      if (evt_i) begin
        // close the interval that ends at this strobe
        if (armed_q) begin
          if (have_prev_q && (cur == prev_q)) err_q <= 1'b1;
          prev_q      <= cur;
          have_prev_q <= 1'b1;
        end
        armed_q <= 1'b1;
        seen_q  <= 1'b0;
      end else begin
        seen_q <= cur;
      end
    end
  end

  assign err_o = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_err_at_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(evt_i));
endmodule

// File: rtl/adc_rc_ctrl.sv
module adc_rc_ctrl
  import adc_rc_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   free_run_i,
  input  logic [DIV_W-1:0]       div_half_i,
  input  logic [GAP_W-1:0]       gap_i,
  output logic                   sclk_o,
  output logic                   strobe_o,
  output logic                   cs_no,
  input  logic                   sdo_i,
  input  logic                   busy_i,
  output logic                   m_valid_o,
  input  logic                   m_ready_i,
  output logic [ID_W+DATA_W-1:0] m_data_o,
  output logic                   sync_err_o
);
  localparam int WORD_W = ID_W + DATA_W;
  localparam int DCW    = $clog2(DATA_W) + 1;
  localparam int CNT_W  = (GAP_W > DCW) ? GAP_W : DCW;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] ID_END = CNT_W'(ID_W - 1);
  localparam logic [CNT_W-1:0] D_END  = CNT_W'(DATA_W - 1);

  rc_state_e         state_q;
  logic              h_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gap_q;
  logic              tick, start, clk_run, active, sample;
  logic [WORD_W-1:0] word;
  logic              m_valid_q;
  logic [WORD_W-1:0] m_data_q;

  assign start   = (state_q == ST_IDLE) && en_i && (!m_valid_q || free_run_i);
  assign clk_run = (state_q == ST_STRB) || (state_q == ST_ID) || (state_q == ST_DATA);
  assign active  = clk_run || (state_q == ST_GAP);
  assign sample  = tick && !h_q && ((state_q == ST_ID) || (state_q == ST_DATA));

  adc_rc_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!active),
    .half_i (div_half_i),
    .tick_o (tick)
  );

  adc_rc_shift #(.W(WORD_W)) u_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .en_i   (sample),
    .bit_i  (sdo_i),
    .word_o (word)
  );

  adc_rc_sync_mon u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_i),
    .evt_i  (start),
    .err_o  (sync_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      h_q     <= 1'b0;
      cnt_q   <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_STRB;
          h_q     <= 1'b0;
          cnt_q   <= '0;
          gap_q   <= gap_i;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: if (tick) begin
          if (!h_q) begin
            h_q <= 1'b1;
          end else begin
            h_q <= 1'b0;
            // period boundary
            unique case (state_q)
              ST_STRB: begin
                state_q <= ST_ID;
                cnt_q   <= '0;
              end
              ST_ID: if (cnt_q == ID_END) begin
                state_q <= (gap_q == '0) ? ST_DATA : ST_GAP;
                cnt_q   <= '0;
              end else cnt_q <= cnt_q + ONE;
              ST_GAP: if ((cnt_q + ONE) == CNT_W'(gap_q)) begin
                state_q <= ST_DATA;
                cnt_q   <= '0;
              end else cnt_q <= cnt_q + ONE;
              ST_DATA: if (cnt_q == D_END) begin
                state_q <= ST_DONE;
                cnt_q   <= '0;
              end else cnt_q <= cnt_q + ONE;
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
    end else if (state_q == ST_DONE) begin
      m_valid_q <= 1'b1;
      m_data_q  <= word;
    end else if (m_ready_i) begin
      m_valid_q <= 1'b0;
    end
  end

  assign strobe_o  = (state_q == ST_STRB);
  assign sclk_o    = clk_run && !h_q;
  assign cs_no     = !active;
  assign m_valid_o = m_valid_q;
  assign m_data_o  = m_data_q;

  assert_strobe_one_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_o) |-> $past(tick) && $past(h_q));
  assert_cs_covers_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o || sclk_o) |-> !cs_no);
  assert_cs_opens_with_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> strobe_o && sclk_o);
  assert_hold_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i && state_q != ST_DONE) |=> m_valid_o && $stable(m_data_o));
  assert_no_start_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !free_run_i && state_q == ST_IDLE) |=> !strobe_o);
endmodule

// File: tb/adc_rc_ctrl_tb_top.sv
module adc_rc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, free_run_i = 1'b0, m_ready_i = 1'b1;
  logic [7:0]  div_half_i = 8'd2;
  logic [3:0]  gap_i = 4'd0;
  logic        sclk_o, strobe_o, cs_no, m_valid_o, sync_err_o;
  logic        sdo_i = 1'b0, busy_i = 1'b0;
  logic [17:0] m_data_o;

  always #2.5 clk = ~clk;

  adc_rc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .free_run_i(free_run_i),
    .div_half_i(div_half_i), .gap_i(gap_i), .sclk_o(sclk_o), .strobe_o(strobe_o),
    .cs_no(cs_no), .sdo_i(sdo_i), .busy_i(busy_i), .m_valid_o(m_valid_o),
    .m_ready_i(m_ready_i), .m_data_o(m_data_o), .sync_err_o(sync_err_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  // converter model and monitors
  logic [1:0]  adc_id = 2'b10;
  logic [15:0] adc_data = 16'h0;
  bit          auto_inc = 0;
  int          busy_mode = 0;  // 0 alternate, 1 every strobe, 2 never
  int          strobe_n = 0, busy_cnt = 0;
  logic [17:0] sh = '0;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          cs_len = 0, strb_len = 0, rises = 0;
  int          last_cs_len = 0, last_strb_len = 0, last_rises = 0, cs_falls = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      summary();
      $finish;
    end
    if (sclk_o && !prev_sclk) begin
      rises++;
      if (strobe_o) begin
        sh = {adc_id, adc_data};
        if (auto_inc) adc_data = adc_data + 16'd1;
        strobe_n++;
        if ((busy_mode == 0 && strobe_n % 2 == 1) || busy_mode == 1) busy_cnt = 4;
      end else begin
        sdo_i = sh[17];
        sh = sh << 1;
      end
    end
    prev_sclk = sclk_o;
    busy_i = (busy_cnt > 0);
    if (busy_cnt > 0) busy_cnt--;
    if (!cs_no) cs_len++;
    if (strobe_o) strb_len++;
    if (!cs_no && prev_cs) cs_falls++;
    if (cs_no && !prev_cs) begin
      last_cs_len = cs_len; last_strb_len = strb_len; last_rises = rises;
      cs_len = 0; strb_len = 0; rises = 0;
    end
    prev_cs = cs_no;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; en_i = 0; free_run_i = 0; m_ready_i = 1; busy_mode = 0;
    auto_inc = 0; strobe_n = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_valid();
    while (!m_valid_o) @(negedge clk);
  endtask

  task automatic one_frame(input logic [1:0] id, input logic [15:0] d,
                           input int g, input int h, output logic [17:0] got);
    adc_id = id; adc_data = d; gap_i = 4'(g); div_half_i = 8'(h);
    m_ready_i = 1; en_i = 1;
    @(negedge clk);
    wait_valid();
    got = m_data_o;
    en_i = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(!strobe_o, "R1 strobe", strobe_o, 0);
    check(!sclk_o, "R1 sclk", sclk_o, 0);
    check(cs_no, "R1 cs", cs_no, 1);
    check(!m_valid_o, "R1 valid", m_valid_o, 0);
    check(!sync_err_o, "R1 sync_err", sync_err_o, 0);
    do_reset();
  endtask

  task automatic t_basic();
    logic [17:0] got;
    do_reset();
    one_frame(2'b10, 16'hA5C3, 0, 2, got);
    check(got == 18'h2A5C3, "R4 R6 word", got, 18'h2A5C3);
    check(last_strb_len == 4, "R2 strobe width", last_strb_len, 4);
    check(last_rises == 19, "R3 sclk rises", last_rises, 19);
    check(last_cs_len == 76, "R3 cs low length", last_cs_len, 76);
    one_frame(2'b01, 16'h0001, 0, 3, got);
    check(got == 18'h10001, "R6 tag pass", got, 18'h10001);
    check(last_strb_len == 6, "R2 strobe width h3", last_strb_len, 6);
  endtask

  task automatic t_gap();
    logic [17:0] got;
    do_reset();
    one_frame(2'b10, 16'h8E71, 3, 2, got);
    check(got == 18'h28E71, "R5 word with gap", got, 18'h28E71);
    check(last_cs_len == 88, "R5 cs length gap3", last_cs_len, 88);
    check(last_rises == 19, "R5 no sclk in gap", last_rises, 19);
  endtask

  task automatic t_backpressure();
    int f0;
    logic [17:0] held;
    do_reset();
    adc_id = 2'b11; adc_data = 16'h1234; gap_i = 0; div_half_i = 2;
    m_ready_i = 0; en_i = 1;
    wait_valid();
    held = m_data_o;
    f0 = cs_falls;
    repeat (300) @(negedge clk);
    check(cs_falls == f0, "R8 no frame while pending", cs_falls, f0);
    check(m_valid_o && m_data_o == held, "R8 sample held", m_data_o, held);
    check(last_cs_len == 76 && cs_no, "R7 cs released", cs_no, 1);
    m_ready_i = 1;
    @(negedge clk);
    m_ready_i = 0;
    repeat (4) @(negedge clk);
    check(cs_falls == f0 + 1, "R8 frame after accept", cs_falls, f0 + 1);
    en_i = 0;
    m_ready_i = 1;
    repeat (100) @(negedge clk);
  endtask

  task automatic t_free_run();
    int f0;
    do_reset();
    adc_id = 2'b00; adc_data = 16'h1000; auto_inc = 1; gap_i = 0; div_half_i = 2;
    m_ready_i = 0; free_run_i = 1; en_i = 1;
    wait_valid();
    f0 = cs_falls;
    while (cs_falls == f0) @(negedge clk);
    while (!cs_no) @(negedge clk);
    repeat (2) @(negedge clk);
    check(m_valid_o && m_data_o == 18'h01001, "R9 replaced sample", m_data_o, 18'h01001);
    check(cs_falls >= 2, "R9 back to back", cs_falls, 2);
    en_i = 0; free_run_i = 0; m_ready_i = 1; auto_inc = 0;
    repeat (100) @(negedge clk);
  endtask

  task automatic run_frames(input int mode, input int n);
    do_reset();
    busy_mode = mode; adc_id = 2'b10; adc_data = 16'h5555; gap_i = 0; div_half_i = 2;
    m_ready_i = 1;
    for (int i = 0; i < n; i++) begin
      en_i = 1;
      @(negedge clk);
      wait_valid();
      en_i = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_sync();
    run_frames(0, 6);
    check(!sync_err_o, "R10 alternating ok", sync_err_o, 0);
    run_frames(1, 3);
    check(sync_err_o, "R10 busy every strobe", sync_err_o, 1);
    run_frames(1, 2);
    check(!sync_err_o, "R10 no decision before third strobe", sync_err_o, 0);
    run_frames(2, 3);
    check(sync_err_o, "R10 busy missing", sync_err_o, 1);
    en_i = 1; @(negedge clk); wait_valid(); en_i = 0;
    check(sync_err_o, "R10 sticky", sync_err_o, 1);
  endtask

  task automatic t_div();
    logic [17:0] got;
    do_reset();
    one_frame(2'b10, 16'hC00F, 0, 0, got);
    check(last_strb_len == 2, "R11 half zero strobe", last_strb_len, 2);
    check(last_cs_len == 38, "R11 half zero frame", last_cs_len, 38);
    check(got == 18'h2C00F, "R11 word at fastest rate", got, 18'h2C00F);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gap();
    t_backpressure();
    t_free_run();
    t_sync();
    t_div();
    summary();
    $finish;
  end
endmodule